// File: doc/BRIEF.md
# Management Event Status Register

This block gathers hardware events of a chipset management controller into one 16-bit status word. Each event sets a sticky bit, and software clears a bit by writing a one to its position. The events are:

- received error, non-maskable, management and configuration-interrupt messages;
- illegal attempts to write the firmware flash;
- the watchdog timer reaching zero;
- a write to the handler's data-out register;
- the calendar year rolling over to a new century.

The block turns the set bits into a system-management interrupt request. It also turns a received error message into an NMI request and a secondary-error flag.

The century bit is held in the slow real-time-clock domain. Its set logic and its own reset run on the RTC clock. A write-one-to-clear of that bit crosses into the RTC domain as a level request and completes a few RTC clocks later. Until the cleared state has come back across, the register keeps reading the bit as set. Software polls the bit until it reads zero before it leaves its handler.

Top module: `evt_status_reg`

## Requirements
- R1: After reset, rd_data_o reads 0000h. Bits 15:13 and 6:4 always read zero.
- R2: Writing clr_data_i with clr_we_i high clears each status bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R3: If a set event and a clear of the same bit fall in the same clk_i cycle, the bit ends up set.
- R4: Each of these pulses sets its bit in the cycle after it is sampled: serr_msg_i sets bit 12, nmi_msg_i sets bit 11, smi_msg_i sets bit 10 and sci_msg_i sets bit 9.
- R5: The error-routing outputs follow bit 12 and serr_en_i:
  - sec_serr_o equals bit 12 AND serr_en_i.
  - nmi_o equals bit 12 AND serr_en_i AND NOT nmi_to_smi_i.
  - When nmi_to_smi_i is high, bit 12 with serr_en_i drives smi_o instead of nmi_o.
- R6: Bit 8 sets when bios_wp_i changes from 0 (previous cycle) to 1 while bios_lock_i is high. The same change with bios_lock_i low does not set bit 8.
- R7: Bit 8 sets on a bios_wr_i cycle while bios_wp_i is high. The exception is a write whose address lies in the lower alias window FF800000h–FFBFFFFFh, which never sets bit 8.
- R8: tmr_zero_i sets bit 3 and dout_wr_i sets bit 2.
- R9: Bit 7 sets when the BCD year on rtc_year_i, sampled on rtc_clk_i, changes from 99h to 00h. Other year changes, such as 98h to 99h, leave it clear.
- R10: After a write-one-to-clear of bit 7, the bit still reads 1 in the next clk_i cycle. It reads 0 once the clear has completed in the RTC domain, within 3 RTC clocks plus the synchronizer delay.
- R11: rtc_rst_ni going low clears bit 7.
- R12: smi_o is the OR of bits 10, 8, 7, 3 and 2, and of the routed error term of R5. It stays high until all of them are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Main active-low asynchronous reset |
| rtc_clk_i | input | 1 | Slow RTC clock |
| rtc_rst_ni | input | 1 | RTC-domain active-low asynchronous reset |
| serr_msg_i | input | 1 | Received error message pulse |
| nmi_msg_i | input | 1 | Received NMI message pulse |
| smi_msg_i | input | 1 | Received SMI message pulse |
| sci_msg_i | input | 1 | Received SCI message pulse |
| serr_en_i | input | 1 | Error reporting enable |
| nmi_to_smi_i | input | 1 | Route error NMI to SMI |
| bios_wr_i | input | 1 | Write cycle decoded to firmware space |
| bios_addr_i | input | ADDR_W | Address of that write |
| bios_wp_i | input | 1 | Firmware write-protect enable |
| bios_lock_i | input | 1 | Write-protect lock-down |
| rtc_year_i | input | 8 | BCD year, RTC domain |
| tmr_zero_i | input | 1 | Watchdog reached zero pulse |
| dout_wr_i | input | 1 | Data-out register write strobe |
| clr_we_i | input | 1 | Status clear write strobe |
| clr_data_i | input | 16 | Write-one-to-clear data |
| rd_data_o | output | 16 | Status read value |
| smi_o | output | 1 | SMI request |
| nmi_o | output | 1 | NMI request |
| sec_serr_o | output | 1 | Secondary system error flag |

## Verification
The hardest case to reach is the century bit's delayed clear. It needs a 99h-to-00h year step on the slow clock, then a write-one-to-clear whose completion trails the write by several RTC clocks. The bench gets there with directed year sequences driven on the RTC clock. It checks that the bit still reads set in the cycle after the write, then polls for it to drop within a bound. The main-domain bits run under random pulses, clears and address choices that often land a set and a clear in the same cycle. Separate directed cases cover an RTC reset and the alias window edges.

// File: rtl/evt_sts_pkg.sv
package evt_sts_pkg;
  localparam int STS_W = 16;
  localparam int B_SERR = 12;
  localparam int B_NMI  = 11;
  localparam int B_SMI  = 10;
  localparam int B_SCI  = 9;
  localparam int B_BWR  = 8;
  localparam int B_CENT = 7;
  localparam int B_TMO  = 3;
  localparam int B_DOUT = 2;
  localparam logic [STS_W-1:0] MAIN_MASK = 16'h1F0C;
  localparam logic [STS_W-1:0] SMI_MASK  = 16'h058C;
  localparam logic [STS_W-1:0] RSVD_MASK = 16'hE070;
endpackage

// File: rtl/evt_sync2.sv
module evt_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/evt_rtc_sts.sv
module evt_rtc_sts (
  input  logic       rtc_clk_i,
  input  logic       rtc_rst_ni,
  input  logic [7:0] year_i,
  input  logic       clr_req_i,
  output logic       sts_o
);
  logic [7:0] year_q;
  logic       clr_req_s;
  logic       sts_q;
  logic       rollover;

  evt_sync2 #(.W(1)) u_req_sync (
    .clk_i (rtc_clk_i),
    .rst_ni(rtc_rst_ni),
    .d_i   (clr_req_i),
    .q_o   (clr_req_s)
  );

  assign rollover = (year_q == 8'h99) && (year_i == 8'h00);

  always_ff @(posedge rtc_clk_i or negedge rtc_rst_ni) begin
    if (!rtc_rst_ni) begin
      year_q <= '0;
      sts_q  <= 1'b0;
    end else begin
      year_q <= year_i;
      if (rollover)       sts_q <= 1'b1;
      else if (clr_req_s) sts_q <= 1'b0;
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/evt_bios_guard.sv
module evt_bios_guard #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'hFF80_0000,
  parameter int ALIAS_LSB = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bios_wr_i,
  input  logic [ADDR_W-1:0] bios_addr_i,
  input  logic              bios_wp_i,
  input  logic              bios_lock_i,
  output logic              viol_o
);
  localparam int TAG_W = ADDR_W - ALIAS_LSB;
  localparam logic [TAG_W-1:0] ALIAS_TAG = ALIAS_BASE[ADDR_W-1:ALIAS_LSB];

  logic wp_q;
  logic in_alias;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_q <= 1'b0;
    else         wp_q <= bios_wp_i;
  end

  assign in_alias = (bios_addr_i[ADDR_W-1:ALIAS_LSB] == ALIAS_TAG);
  assign viol_o   = (bios_wp_i && !wp_q && bios_lock_i) ||
                    (bios_wr_i && bios_wp_i && !in_alias);
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_sts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'hFF80_0000,
  parameter int ALIAS_LSB = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_clk_i,
  input  logic              rtc_rst_ni,
  input  logic              serr_msg_i,
  input  logic              nmi_msg_i,
  input  logic              smi_msg_i,
  input  logic              sci_msg_i,
  input  logic              serr_en_i,
  input  logic              nmi_to_smi_i,
  input  logic              bios_wr_i,
  input  logic [ADDR_W-1:0] bios_addr_i,
  input  logic              bios_wp_i,
  input  logic              bios_lock_i,
  input  logic [7:0]        rtc_year_i,
  input  logic              tmr_zero_i,
  input  logic              dout_wr_i,
  input  logic              clr_we_i,
  input  logic [STS_W-1:0]  clr_data_i,
  output logic [STS_W-1:0]  rd_data_o,
  output logic              smi_o,
  output logic              nmi_o,
  output logic              sec_serr_o
);
  logic [STS_W-1:0] sts_q;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] clr_vec;
  logic             bios_viol;
  logic             cent_rtc;
  logic             cent_s;
  logic             cent_clr_pend_q;
  logic             serr_route;

  evt_bios_guard #(
    .ADDR_W    (ADDR_W),
    .ALIAS_BASE(ALIAS_BASE),
    .ALIAS_LSB (ALIAS_LSB)
  ) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bios_wr_i  (bios_wr_i),
    .bios_addr_i(bios_addr_i),
    .bios_wp_i  (bios_wp_i),
    .bios_lock_i(bios_lock_i),
    .viol_o     (bios_viol)
  );

  evt_rtc_sts u_rtc (
    .rtc_clk_i (rtc_clk_i),
    .rtc_rst_ni(rtc_rst_ni),
    .year_i    (rtc_year_i),
    .clr_req_i (cent_clr_pend_q),
    .sts_o     (cent_rtc)
  );

  evt_sync2 #(.W(1)) u_cent_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cent_rtc),
    .q_o   (cent_s)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_SERR] = serr_msg_i;
    set_vec[B_NMI]  = nmi_msg_i;
    set_vec[B_SMI]  = smi_msg_i;
    set_vec[B_SCI]  = sci_msg_i;
    set_vec[B_BWR]  = bios_viol;
    set_vec[B_TMO]  = tmr_zero_i;
    set_vec[B_DOUT] = dout_wr_i;
  end

  assign clr_vec = clr_we_i ? clr_data_i : '0;

  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    if (MAIN_MASK[i]) begin : g_main
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sts_q[i] <= 1'b0;
        else         sts_q[i] <= set_vec[i] | (sts_q[i] & ~clr_vec[i]);
      end
    end else begin : g_none
      assign sts_q[i] = 1'b0;
    end
  end

  // level request held until the cleared state returns across the crossing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cent_clr_pend_q <= 1'b0;
    else if (cent_clr_pend_q) cent_clr_pend_q <= cent_s;
    else                      cent_clr_pend_q <= clr_vec[B_CENT] & cent_s;
  end

  always_comb begin
    rd_data_o         = sts_q;
    rd_data_o[B_CENT] = cent_s;
  end

  assign serr_route = rd_data_o[B_SERR] & serr_en_i;
  assign sec_serr_o = serr_route;
  assign nmi_o      = serr_route & ~nmi_to_smi_i;
  assign smi_o      = (|(rd_data_o & SMI_MASK)) | (serr_route & nmi_to_smi_i);
endmodule

// File: rtl/evt_status_reg_chk.sv
module evt_status_reg_chk
  import evt_sts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'hFF80_0000,
  parameter int ALIAS_LSB = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sci_msg_i,
  input logic              serr_msg_i,
  input logic              nmi_to_smi_i,
  input logic              bios_wr_i,
  input logic [ADDR_W-1:0] bios_addr_i,
  input logic              bios_wp_i,
  input logic              tmr_zero_i,
  input logic              clr_we_i,
  input logic [STS_W-1:0]  clr_data_i,
  input logic [STS_W-1:0]  rd_data_o,
  input logic              smi_o,
  input logic              nmi_o
);
  logic outside_alias;
  assign outside_alias = bios_addr_i[ADDR_W-1:ALIAS_LSB] != ALIAS_BASE[ADDR_W-1:ALIAS_LSB];

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & RSVD_MASK) == '0);
  p_w0_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !clr_data_i[B_NMI] && rd_data_o[B_NMI]) |=> rd_data_o[B_NMI]);
  p_w1_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_data_i[B_SCI] && !sci_msg_i) |=> !rd_data_o[B_SCI]);
  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_zero_i |=> rd_data_o[B_TMO]);
  p_serr_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_msg_i |=> rd_data_o[B_SERR]);
  p_nmi_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nmi_o && nmi_to_smi_i));
  p_bios_viol_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bios_wr_i && bios_wp_i && outside_alias) |=> rd_data_o[B_BWR]);
  p_smi_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[B_TMO] || rd_data_o[B_CENT]) |-> smi_o);
endmodule

bind evt_status_reg evt_status_reg_chk #(
  .ADDR_W    (ADDR_W),
  .ALIAS_BASE(ALIAS_BASE),
  .ALIAS_LSB (ALIAS_LSB)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sci_msg_i   (sci_msg_i),
  .serr_msg_i  (serr_msg_i),
  .nmi_to_smi_i(nmi_to_smi_i),
  .bios_wr_i   (bios_wr_i),
  .bios_addr_i (bios_addr_i),
  .bios_wp_i   (bios_wp_i),
  .tmr_zero_i  (tmr_zero_i),
  .clr_we_i    (clr_we_i),
  .clr_data_i  (clr_data_i),
  .rd_data_o   (rd_data_o),
  .smi_o       (smi_o),
  .nmi_o       (nmi_o)
);

// File: tb/evt_status_reg_bench.sv
module evt_status_reg_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0, rtc_clk_i = 1'b0, rtc_rst_ni = 1'b0;
  logic        serr_msg_i = 0, nmi_msg_i = 0, smi_msg_i = 0, sci_msg_i = 0;
  logic        serr_en_i = 0, nmi_to_smi_i = 0;
  logic        bios_wr_i = 0, bios_wp_i = 0, bios_lock_i = 0;
  logic [31:0] bios_addr_i = '0;
  logic [7:0]  rtc_year_i = 8'h00;
  logic        tmr_zero_i = 0, dout_wr_i = 0, clr_we_i = 0;
  logic [15:0] clr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        smi_o, nmi_o, sec_serr_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_sts = '0;
  logic        wp_prev = 1'b0;
  bit          done = 0;

  always #5 clk_i = ~clk_i;
  always #35 rtc_clk_i = ~rtc_clk_i;

  evt_status_reg u_evt_status_reg (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic in_alias(logic [31:0] a);
    return a[31:22] == 10'h3FE;
  endfunction

  function automatic logic [15:0] set_model(logic s, logic n, logic m, logic c, logic bw,
      logic [31:0] ad, logic wp, logic wpp, logic lk, logic tz, logic dw);
    logic [15:0] v = '0;
    v[12] = s; v[11] = n; v[10] = m; v[9] = c;
    v[8]  = (wp && !wpp && lk) || (bw && wp && !in_alias(ad));
    v[3]  = tz; v[2] = dw;
    return v;
  endfunction

  // apply current inputs to the model (call after driving at negedge)
  task automatic model_step();
    logic [15:0] clr = clr_we_i ? clr_data_i : 16'h0;
    exp_sts = set_model(serr_msg_i, nmi_msg_i, smi_msg_i, sci_msg_i, bios_wr_i, bios_addr_i,
                        bios_wp_i, wp_prev, bios_lock_i, tmr_zero_i, dout_wr_i)
              | (exp_sts & ~clr & 16'h1F0C);
    wp_prev = bios_wp_i;
  endtask

  task automatic idle();
    serr_msg_i = 0; nmi_msg_i = 0; smi_msg_i = 0; sci_msg_i = 0;
    bios_wr_i = 0; tmr_zero_i = 0; dout_wr_i = 0; clr_we_i = 0; clr_data_i = '0;
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk_i);
  endtask

  function automatic logic exp_smi(logic [15:0] s, logic b7);
    return |(s & 16'h050C) | b7 | (s[12] & serr_en_i & nmi_to_smi_i);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    rst_ni = 1; rtc_rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset value", rd_data_o, 16'h0000);
    chk("R12 smi idle", smi_o, 1'b0);

    // R4 message bits
    serr_msg_i = 1; nmi_msg_i = 1; smi_msg_i = 1; sci_msg_i = 1; cyc(); idle();
    chk("R4 msg bits", rd_data_o, 16'h1E00);
    // R5 routing
    serr_en_i = 1; nmi_to_smi_i = 0; #1;
    chk("R5 nmi", {sec_serr_o, nmi_o}, 2'b11);
    nmi_to_smi_i = 1; #1;
    chk("R5 routed", {sec_serr_o, nmi_o, smi_o}, 3'b101);
    // R2 write zeros no effect, then clear subset
    clr_we_i = 1; clr_data_i = 16'h0000; cyc(); idle();
    chk("R2 w0 keep", rd_data_o, 16'h1E00);
    clr_we_i = 1; clr_data_i = 16'h1400; cyc(); idle();
    chk("R2 w1 clear", rd_data_o, 16'h0A00);
    serr_en_i = 0; nmi_to_smi_i = 0;
    clr_we_i = 1; clr_data_i = 16'hFFFF; cyc(); idle();
    chk("R2 clear all", rd_data_o, 16'h0000);
    // R3 set wins
    tmr_zero_i = 1; clr_we_i = 1; clr_data_i = 16'h0008; cyc(); idle();
    chk("R3 set wins", rd_data_o, 16'h0008);
    dout_wr_i = 1; cyc(); idle();
    chk("R8 tmr and dout", rd_data_o, 16'h000C);
    chk("R12 smi on", smi_o, 1'b1);
    clr_we_i = 1; clr_data_i = 16'h0008; cyc(); idle();
    chk("R12 smi held by bit2", smi_o, 1'b1);
    clr_we_i = 1; clr_data_i = 16'h0004; cyc(); idle();
    chk("R12 smi drops", smi_o, 1'b0);
    // R6 wp rise without and with lock
    bios_lock_i = 0; bios_wp_i = 1; cyc();
    chk("R6 no lock", rd_data_o[8], 1'b0);
    bios_wp_i = 0; cyc();
    bios_lock_i = 1; bios_wp_i = 1; cyc();
    chk("R6 locked rise", rd_data_o[8], 1'b1);
    clr_we_i = 1; clr_data_i = 16'h0100; cyc(); idle();
    chk("R6 cleared", rd_data_o[8], 1'b0);
    // R7 alias window edges
    bios_wr_i = 1; bios_addr_i = 32'hFF80_0000; cyc(); idle();
    chk("R7 alias low edge", rd_data_o[8], 1'b0);
    bios_wr_i = 1; bios_addr_i = 32'hFFBF_FFFF; cyc(); idle();
    chk("R7 alias high edge", rd_data_o[8], 1'b0);
    bios_wr_i = 1; bios_addr_i = 32'hFFC0_0000; cyc(); idle();
    chk("R7 real space", rd_data_o[8], 1'b1);
    bios_wp_i = 0; bios_lock_i = 0;
    clr_we_i = 1; clr_data_i = 16'hFFFF; cyc(); idle();
    bios_wr_i = 1; bios_addr_i = 32'hFFF0_0000; cyc(); idle();
    chk("R7 wp off", rd_data_o[8], 1'b0);

    // random phase: R2 R3 R4 R5 R6 R7 R8 R12
    for (int k = 0; k < 600; k++) begin
      serr_msg_i = ($urandom % 8) == 0; nmi_msg_i = ($urandom % 8) == 0;
      smi_msg_i = ($urandom % 8) == 0;  sci_msg_i = ($urandom % 8) == 0;
      tmr_zero_i = ($urandom % 8) == 0; dout_wr_i = ($urandom % 8) == 0;
      bios_wp_i = ($urandom % 4) != 0;  bios_lock_i = $urandom % 2;
      bios_wr_i = ($urandom % 4) == 0;
      case ($urandom % 3)
        0: bios_addr_i = 32'hFF80_0000 | ($urandom & 32'h003F_FFFF);
        1: bios_addr_i = 32'hFFC0_0000 | ($urandom & 32'h003F_FFFF);
        default: bios_addr_i = $urandom;
      endcase
      clr_we_i = ($urandom % 3) == 0; clr_data_i = 16'($urandom) & 16'hFF7F;
      cyc();
      chk("R2 R4 R7 R8 random sts", rd_data_o, exp_sts);
      chk("R12 random smi", smi_o, exp_smi(exp_sts, 1'b0));
      chk("R5 random nmi", {sec_serr_o, nmi_o},
          {exp_sts[12] & serr_en_i, exp_sts[12] & serr_en_i & ~nmi_to_smi_i});
      serr_en_i = $urandom % 2; nmi_to_smi_i = $urandom % 2;
    end
    idle(); bios_wp_i = 0; bios_lock_i = 0; serr_en_i = 0;
    clr_we_i = 1; clr_data_i = 16'hFFFF; cyc(); idle(); cyc();
    chk("R2 clear after random", rd_data_o, 16'h0000);

    // R9 century rollover
    @(negedge rtc_clk_i); rtc_year_i = 8'h98;
    @(negedge rtc_clk_i); rtc_year_i = 8'h99;
    repeat (3) @(negedge rtc_clk_i);
    @(negedge clk_i);
    chk("R9 98 to 99 no set", rd_data_o[7], 1'b0);
    @(negedge rtc_clk_i); rtc_year_i = 8'h00;
    repeat (3) @(negedge rtc_clk_i);
    @(negedge clk_i);
    chk("R9 99 to 00 sets", rd_data_o[7], 1'b1);
    chk("R12 smi from bit7", smi_o, 1'b1);

    // R10 delayed clear
    clr_we_i = 1; clr_data_i = 16'h0080; @(negedge clk_i); idle();
    chk("R10 still set after write", rd_data_o[7], 1'b1);
    begin
      int w = 0;
      while (rd_data_o[7] && w < 60) begin @(negedge clk_i); w++; end
      chk("R10 clear completes", rd_data_o[7], 1'b0);
      chk("R10 clear delayed", w > 0, 1'b1);
    end
    repeat (6) @(negedge rtc_clk_i);
    @(negedge clk_i);
    chk("R10 stays clear", rd_data_o[7], 1'b0);

    // R11 rtc reset clears bit 7
    @(negedge rtc_clk_i); rtc_year_i = 8'h99;
    @(negedge rtc_clk_i); rtc_year_i = 8'h00;
    repeat (3) @(negedge rtc_clk_i);
    @(negedge clk_i);
    chk("R11 set before rtc reset", rd_data_o[7], 1'b1);
    rtc_rst_ni = 0;
    repeat (4) @(negedge clk_i);
    chk("R11 cleared by rtc reset", rd_data_o[7], 1'b0);
    rtc_rst_ni = 1;
    @(negedge clk_i);
    chk("R1 final reserved zero", rd_data_o & 16'hE070, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule